// File: doc/BRIEF.md
# NAND Page ECC Single-Bit Corrector

This block checks a 512-byte flash data block against its 24-bit row/column parity code. The code read back from the flash and the code recomputed over the data arrive together on a valid/ready input. The block XORs the two codes into a 24-bit syndrome and sorts it into one of four verdicts: clean, a single-bit error in the data, a single-bit error in the stored code, or uncorrectable. For a data error it also reports the faulty byte address (9 bits) and bit index (3 bits).

The verdict is registered and held. A second stage then lets the data bytes pass through, each tagged with its byte index. When the held verdict is a data error and a byte's index matches the held address, that byte leaves with the faulty bit inverted. Every other byte leaves unchanged, one cycle after it entered.

Top module: `nand_ecc_fix`

## Requirements
- R1: The syndrome is stored code XOR recomputed code. Syndrome byte k (k = 0, 1, 2) is bits 8k+7..8k of the 24-bit code ports, and is called dk below.
- R2: A zero syndrome gives status 2'b00 (clean) with address and bit index 0. Every streamed byte passes through unchanged.
- R3: Status is 2'b01 (corrected in data) only if, in each of d0, d1 and d2, every even bit 2j differs from bit 2j+1.
- R4: For status 2'b01, bit index bit 0 is d2 bit 2, bit 1 is d2 bit 4 and bit 2 is d2 bit 6.
- R5: For status 2'b01, byte address bits 0..3 are d0 bits 0, 2, 4, 6 and address bits 4..7 are d1 bits 0, 2, 4, 6, in that order.
- R6: For status 2'b01, byte address bit 8 is d2 bit 0, so any of the 512 bytes can be addressed.
- R7: While the held status is 2'b01, the streamed byte whose index equals the held address leaves XORed with a one-hot mask at the held bit index.
- R8: A syndrome that fails the R3 test but has exactly one bit set gives status 2'b10 (corrected in code), with address and bit index 0. Streamed data is left unchanged.
- R9: Any other non-zero syndrome gives status 2'b11 (uncorrectable), with address and bit index 0. Streamed data is left unchanged.
- R10: res_valid pulses for one cycle, in the cycle after an accepted input (in_valid and in_ready). Status, address and bit index update at that edge and hold until the next accepted input.
- R11: Each streamed byte appears on the outputs one cycle after it is presented, together with its index and with out_valid set.
- R12: A synchronous active-high reset clears the held status to clean and deasserts res_valid and out_valid. in_ready is high whenever reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Code pair valid |
| in_ready | output | 1 | Block accepts a code pair |
| code_stored | input | 24 | Parity code read back from flash |
| code_calc | input | 24 | Parity code recomputed from the data |
| res_valid | output | 1 | One-cycle pulse when a new verdict is held |
| res_status | output | 2 | Held verdict: 00 clean, 01 data, 10 code, 11 uncorrectable |
| res_addr | output | 9 | Held faulty byte address |
| res_bit | output | 3 | Held faulty bit index |
| dat_valid | input | 1 | Streamed byte valid |
| dat_idx | input | 9 | Index of the streamed byte |
| dat_in | input | 8 | Streamed data byte |
| out_valid | output | 1 | Output byte valid |
| out_idx | output | 9 | Index of the output byte |
| out_byte | output | 8 | Data byte, corrected if it was addressed |

## Verification
The hardest case to reach is a syndrome that passes the pair test in all three bytes. Syndromes with that pattern are a vanishing fraction of the 2^24 possible values, so the stimulus does not search for them. It builds each one from a chosen byte address and bit index, setting every even/odd pair to (location bit, its inverse). This encodes in the opposite direction from the decoder, so the expected location does not depend on the RTL's own mapping. Near misses come from such a syndrome with one pair forced equal, which checks the boundary between a data error and an uncorrectable one. Single-bit syndromes placed in each syndrome byte exercise the code-error path.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
   typedef enum logic [1:0] {
      ECC_CLEAN    = 2'b00,
      ECC_FIX_DATA = 2'b01,
      ECC_FIX_CODE = 2'b10,
      ECC_FAIL     = 2'b11
   } ecc_status_e;
endpackage

// File: rtl/ecc_syndrome_decode.sv
module ecc_syndrome_decode
   import nand_ecc_pkg::*;
#(
   parameter int CODE_BYTES = 3,
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 9,
   parameter int BIT_W      = 3
) (
   input  logic [CODE_BYTES*BYTE_W-1:0] stored,
   input  logic [CODE_BYTES*BYTE_W-1:0] calc,
   output ecc_status_e                  status,
   output logic [ADDR_W-1:0]            addr,
   output logic [BIT_W-1:0]             bit_idx
);
   localparam int CODE_W = CODE_BYTES * BYTE_W;
   localparam int PAIRS  = BYTE_W / 2;
   localparam int LOC_W  = CODE_BYTES * PAIRS;

   if (LOC_W != ADDR_W + BIT_W) begin : g_bad_split
      $error("location bits must equal address plus bit index width");
   end
   if (BYTE_W % 2 != 0) begin : g_bad_byte
      $error("byte width must be even");
   end

   logic [CODE_W-1:0] syn;
   logic [LOC_W-1:0]  pair_ok;
   logic [LOC_W-1:0]  loc;
   logic              pattern_ok;
   logic              one_hot;

   assign syn = stored ^ calc;

   for (genvar b = 0; b < CODE_BYTES; b++) begin : g_byte
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
         assign pair_ok[b*PAIRS+p] = syn[b*BYTE_W+2*p] ^ syn[b*BYTE_W+2*p+1];
         assign loc[b*PAIRS+p]     = syn[b*BYTE_W+2*p];
      end
   end

   assign pattern_ok = &pair_ok;
   assign one_hot    = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

   always_comb begin
      status  = ECC_CLEAN;
      addr    = '0;
      bit_idx = '0;
      if (syn == '0) begin
         status = ECC_CLEAN;
      end else if (pattern_ok) begin
         status  = ECC_FIX_DATA;
         addr    = loc[ADDR_W-1:0];
         bit_idx = loc[LOC_W-1:ADDR_W];
      end else if (one_hot) begin
         status = ECC_FIX_CODE;
      end else begin
         status = ECC_FAIL;
      end
   end
endmodule

// File: rtl/ecc_verdict_reg.sv
module ecc_verdict_reg
   import nand_ecc_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int BIT_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  ecc_status_e       status_d,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [BIT_W-1:0]  bit_d,
   output logic              res_valid,
   output ecc_status_e       status_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BIT_W-1:0]  bit_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
         status_q  <= ECC_CLEAN;
         addr_q    <= '0;
         bit_q     <= '0;
      end else begin
         res_valid <= fire;
         if (fire) begin
            status_q <= status_d;
            addr_q   <= addr_d;
            bit_q    <= bit_d;
         end
      end
   end

   assert_pulse_after_fire_R10 : assert property (@(posedge clk) disable iff (rst)
      fire |=> res_valid);
   assert_no_pulse_idle_R10 : assert property (@(posedge clk) disable iff (rst)
      !fire |=> !res_valid);
   assert_verdict_held_R10 : assert property (@(posedge clk) disable iff (rst)
      !fire |=> $stable(status_q) && $stable(addr_q) && $stable(bit_q));
   assert_loc_zero_unless_data_R8 : assert property (@(posedge clk) disable iff (rst)
      fire && status_d != ECC_FIX_DATA |=> addr_q == '0 && bit_q == '0);
endmodule

// File: rtl/ecc_stream_fix.sv
module ecc_stream_fix
   import nand_ecc_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int BIT_W  = 3,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  ecc_status_e       status_q,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [BIT_W-1:0]  bit_q,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_idx,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_idx,
   output logic [BYTE_W-1:0] out_byte
);
   logic              hit;
   logic [BYTE_W-1:0] mask;

   assign hit  = (status_q == ECC_FIX_DATA) && (in_idx == addr_q);
   assign mask = hit ? (BYTE_W'(1) << bit_q) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_idx   <= '0;
         out_byte  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_idx  <= in_idx;
            out_byte <= in_byte ^ mask;
         end
      end
   end

   assert_stream_latency_R11 : assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid && out_idx == $past(in_idx));
   assert_single_flip_R7 : assert property (@(posedge clk) disable iff (rst)
      in_valid && status_q == ECC_FIX_DATA && in_idx == addr_q
      |=> $countones(out_byte ^ $past(in_byte)) == 1);
   assert_untouched_R9 : assert property (@(posedge clk) disable iff (rst)
      in_valid && status_q != ECC_FIX_DATA |=> out_byte == $past(in_byte));
endmodule

// File: rtl/nand_ecc_fix.sv
module nand_ecc_fix
   import nand_ecc_pkg::*;
#(
   parameter int CODE_BYTES = 3,
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 9,
   parameter int BIT_W      = 3
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [CODE_BYTES*BYTE_W-1:0] code_stored,
   input  logic [CODE_BYTES*BYTE_W-1:0] code_calc,
   output logic                         res_valid,
   output logic [1:0]                   res_status,
   output logic [ADDR_W-1:0]            res_addr,
   output logic [BIT_W-1:0]             res_bit,
   input  logic                         dat_valid,
   input  logic [ADDR_W-1:0]            dat_idx,
   input  logic [BYTE_W-1:0]            dat_in,
   output logic                         out_valid,
   output logic [ADDR_W-1:0]            out_idx,
   output logic [BYTE_W-1:0]            out_byte
);
   ecc_status_e       dec_status;
   logic [ADDR_W-1:0] dec_addr;
   logic [BIT_W-1:0]  dec_bit;
   ecc_status_e       held_status;
   logic              fire;

   assign in_ready   = !rst;
   assign fire       = in_valid && in_ready;
   assign res_status = held_status;

   ecc_syndrome_decode #(
      .CODE_BYTES(CODE_BYTES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)
   ) u_decode (
      .stored (code_stored),
      .calc   (code_calc),
      .status (dec_status),
      .addr   (dec_addr),
      .bit_idx(dec_bit)
   );

   ecc_verdict_reg #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_verdict (
      .clk      (clk),
      .rst      (rst),
      .fire     (fire),
      .status_d (dec_status),
      .addr_d   (dec_addr),
      .bit_d    (dec_bit),
      .res_valid(res_valid),
      .status_q (held_status),
      .addr_q   (res_addr),
      .bit_q    (res_bit)
   );

   ecc_stream_fix #(.ADDR_W(ADDR_W), .BIT_W(BIT_W), .BYTE_W(BYTE_W)) u_stream (
      .clk      (clk),
      .rst      (rst),
      .status_q (held_status),
      .addr_q   (res_addr),
      .bit_q    (res_bit),
      .in_valid (dat_valid),
      .in_idx   (dat_idx),
      .in_byte  (dat_in),
      .out_valid(out_valid),
      .out_idx  (out_idx),
      .out_byte (out_byte)
   );

   assert_clean_on_equal_R2 : assert property (@(posedge clk) disable iff (rst)
      fire && code_stored == code_calc |=> res_status == 2'b00);
   assert_data_needs_pairs_R3 : assert property (@(posedge clk) disable iff (rst)
      fire |=> res_status != 2'b01
               || $countones($past(code_stored ^ code_calc)) == CODE_BYTES*BYTE_W/2);
endmodule

// File: tb/nand_ecc_fix_bench.sv
`timescale 1ns/1ps
module nand_ecc_fix_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [23:0] code_stored = '0;
   logic [23:0] code_calc = '0;
   logic        res_valid;
   logic [1:0]  res_status;
   logic [8:0]  res_addr;
   logic [2:0]  res_bit;
   logic        dat_valid = 1'b0;
   logic [8:0]  dat_idx = '0;
   logic [7:0]  dat_in = '0;
   logic        out_valid;
   logic [8:0]  out_idx;
   logic [7:0]  out_byte;

   always #2.5 clk = ~clk;

   nand_ecc_fix u_nand_ecc_fix (.*);

   typedef struct {
      logic [1:0] st;
      logic [8:0] addr;
      logic [2:0] bt;
      string      req;
   } res_item_t;

   typedef struct {
      logic [8:0] idx;
      logic [7:0] val;
      string      req;
   } byte_item_t;

   res_item_t  res_q[$];
   byte_item_t byte_q[$];
   int compared = 0;
   int mismatched = 0;

   logic [1:0] cur_st = 2'b00;
   logic [8:0] cur_addr = '0;
   logic [2:0] cur_bt = '0;

   // Encode a data-error syndrome from its location: each pair is (bit, ~bit)
   function automatic logic [23:0] make_syn(input logic [8:0] a, input logic [2:0] b);
      logic [11:0] loc;
      logic [23:0] s;
      loc = {b, a};
      for (int k = 0; k < 12; k++) begin
         s[2*k]   = loc[k];
         s[2*k+1] = ~loc[k];
      end
      return s;
   endfunction

   task automatic send(input logic [23:0] calc, input logic [23:0] syn,
                       input logic [1:0] st, input logic [8:0] a,
                       input logic [2:0] b, input string req);
      res_item_t it;
      @(negedge clk);
      in_valid    = 1'b1;
      code_calc   = calc;
      code_stored = calc ^ syn;
      it.st = st; it.addr = a; it.bt = b; it.req = req;
      res_q.push_back(it);
      cur_st = st; cur_addr = a; cur_bt = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic stream(input logic [8:0] idx, input logic [7:0] val, input string req);
      byte_item_t it;
      @(negedge clk);
      dat_valid = 1'b1;
      dat_idx   = idx;
      dat_in    = val;
      it.idx = idx;
      it.val = (cur_st == 2'b01 && idx == cur_addr) ? (val ^ (8'd1 << cur_bt)) : val;
      it.req = req;
      byte_q.push_back(it);
      @(negedge clk);
      dat_valid = 1'b0;
   endtask

   task automatic stream_set(input string req);
      stream(cur_addr, 8'h5A, req);
      stream(cur_addr ^ 9'd1, 8'hC3, req);
      stream(9'd0, 8'h00, req);
      stream(9'd511, 8'hFF, req);
   endtask

   // Result monitor (R10): one item per res_valid pulse
   always @(posedge clk) begin
      #1;
      if (!rst && res_valid) begin
         compared++;
         if (res_q.size() == 0) begin
            mismatched++;
            $display("FAIL R10: unexpected res_valid, actual 1 expected 0");
         end else begin
            res_item_t e;
            e = res_q.pop_front();
            if (res_status !== e.st || res_addr !== e.addr || res_bit !== e.bt) begin
               mismatched++;
               $display("FAIL %s: actual st=%b addr=%0d bit=%0d expected st=%b addr=%0d bit=%0d",
                        e.req, res_status, res_addr, res_bit, e.st, e.addr, e.bt);
            end
         end
      end
   end

   // Stream monitor (R7, R11)
   always @(posedge clk) begin
      #1;
      if (!rst && out_valid) begin
         compared++;
         if (byte_q.size() == 0) begin
            mismatched++;
            $display("FAIL R11: unexpected out_valid, actual 1 expected 0");
         end else begin
            byte_item_t e;
            e = byte_q.pop_front();
            if (out_idx !== e.idx || out_byte !== e.val) begin
               mismatched++;
               $display("FAIL %s: actual idx=%0d byte=%h expected idx=%0d byte=%h",
                        e.req, out_idx, out_byte, e.idx, e.val);
            end
         end
      end
   end

   task automatic finish_run();
      compared++;
      if (res_q.size() != 0 || byte_q.size() != 0) begin
         mismatched++;
         $display("FAIL R11: pending items actual %0d/%0d expected 0/0",
                  res_q.size(), byte_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog: run actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      compared++;
      if (res_valid !== 1'b0 || out_valid !== 1'b0 || res_status !== 2'b00) begin
         mismatched++;
         $display("FAIL R12: actual rv=%b ov=%b st=%b expected 0 0 00",
                  res_valid, out_valid, res_status);
      end
      rst = 1'b0;
      @(negedge clk);
      compared++;
      if (in_ready !== 1'b1) begin
         mismatched++;
         $display("FAIL R12: in_ready actual %b expected 1", in_ready);
      end
      // R12: held status clean after reset, so data passes through
      stream_set("R12");

      // R1, R2: equal codes give a zero syndrome
      send(24'hA5C3F0, 24'h000000, 2'b00, 9'd0, 3'd0, "R2");
      stream_set("R2");

      // R3..R6 and R7: data errors at corners and inside
      send(24'h123456, make_syn(9'd0, 3'd0), 2'b01, 9'd0, 3'd0, "R3");
      stream_set("R7");
      send(24'h0F0F0F, make_syn(9'd511, 3'd7), 2'b01, 9'd511, 3'd7, "R6");
      stream_set("R7");
      send(24'hFFFFFF, make_syn(9'h0A5, 3'd3), 2'b01, 9'h0A5, 3'd3, "R5");
      stream_set("R7");
      send(24'h3C3C3C, make_syn(9'h100, 3'd5), 2'b01, 9'h100, 3'd5, "R6");
      stream_set("R7");
      send(24'h000000, make_syn(9'h05A, 3'd6), 2'b01, 9'h05A, 3'd6, "R4");
      stream_set("R4");

      // R8: single-bit syndromes in each syndrome byte
      send(24'h777777, 24'h000001, 2'b10, 9'd0, 3'd0, "R8");
      stream_set("R8");
      send(24'h111111, 24'h800000, 2'b10, 9'd0, 3'd0, "R8");
      send(24'h222222, 24'h000200, 2'b10, 9'd0, 3'd0, "R8");
      stream_set("R8");

      // R9: two bits, all ones, and one equal pair in an otherwise valid pattern
      send(24'h444444, 24'h000003, 2'b11, 9'd0, 3'd0, "R9");
      send(24'h555555, 24'hFFFFFF, 2'b11, 9'd0, 3'd0, "R9");
      stream_set("R9");
      send(24'h666666, make_syn(9'h055, 3'd2) ^ 24'h020000, 2'b11, 9'd0, 3'd0, "R3");
      send(24'h999999, make_syn(9'h1FF, 3'd1) ^ 24'h000040, 2'b11, 9'd0, 3'd0, "R3");
      stream_set("R9");

      // R10: back-to-back accepts, last verdict held while streaming
      send(24'hABCDEF, make_syn(9'd7, 3'd1), 2'b01, 9'd7, 3'd1, "R10");
      send(24'hABCDEF, 24'h000000, 2'b00, 9'd0, 3'd0, "R10");
      stream(9'd7, 8'h81, "R10");

      repeat (4) @(posedge clk);
      finish_run();
   end
endmodule